// File: doc/BRIEF.md
# Wide Unsigned Maximum by One-Hot Reduction

This block returns the largest of 256 unsigned 4-bit values in a single combinational pass. It does not compare values in pairs. Each value is expanded into a 16-bit one-hot code. For every possible value, an OR reduction over all lanes records whether that value occurs anywhere. This gives a 16-bit presence vector. A priority arbiter keeps only the highest set bit of that vector, and an encoder turns the surviving bit back into a 4-bit number.

The block fits where a wide set of small scores, levels or priorities must be reduced to its peak, and where a log-depth OR network is cheaper than a comparator tree. All values arrive on one flat bus. The result appears on a 4-bit output with no clock, and no storage is involved. The lane that holds the peak is not reported.

Top module: `maxoh_max`

## Requirements
- R1: `max_o` equals the largest of the 256 unsigned values present on `vals_i`, for any mix of values.
- R2: Lane k (k = 0..255) is read from `vals_i[4k+3:4k]`; a single lane holding 15 while every other lane holds 0 gives 15, whichever lane it is.
- R3: When every lane holds 0, `max_o` is 0.
- R4: When every lane holds the same value v, `max_o` is v, for each v from 0 to 15.
- R5: Lanes that hold values below the peak never change the result: one lane at m and all others at random values below m gives m.
- R6: The output is a pure function of the current input. It follows a change of `vals_i` without any clock edge, and it does not depend on earlier inputs.
- R7: Inside the block, exactly one arbiter grant is active. That grant sits on a value that is present, and no present value lies above `max_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vals_i | input | 1024 | 256 packed unsigned 4-bit values, lane k at bits [4k+3:4k] |
| max_o | output | 4 | Largest value among all lanes |

## Verification
The hardest cases to reach from the ports are those where the peak sits in a single lane while every other lane sits just below it. In those cases one stray bit in one OR tree, or one wrong link in the arbiter chain, decides the answer. Random vectors almost never produce this. The stimulus therefore walks a lone 15 through all 256 lanes against a zero background, which exercises each leaf of the top OR tree. For each possible peak m, it also places m in one lane over a random background of smaller values. Uniform vectors for all 16 values complete the sweep, so every presence bit is the sole winner at least once.

// File: rtl/maxoh_pkg.sv
// Package maxoh_pkg
// Purpose : shared constant functions for sizing the radix-R OR reduction trees.
// Assumes : the tree input count is a power of the radix.
package maxoh_pkg;

    // Number of reduction levels needed to bring n leaves down to one node.
    function automatic int tree_levels(input int n, input int r);
        int cnt;
        int lv;
        cnt = n;
        lv  = 0;
        while (cnt > 1) begin
            cnt = cnt / r;
            lv  = lv + 1;
        end
        return lv;
    endfunction

    // Number of nodes on a given level (level 0 holds the leaves).
    function automatic int level_width(input int n, input int r, input int lvl);
        int cnt;
        cnt = n;
        for (int i = 0; i < lvl; i++) cnt = cnt / r;
        return cnt;
    endfunction

    // Start index of a level inside the flat node vector.
    function automatic int level_offset(input int n, input int r, input int lvl);
        int acc;
        acc = 0;
        for (int i = 0; i < lvl; i++) acc = acc + level_width(n, r, i);
        return acc;
    endfunction

endpackage

// File: rtl/maxoh_decode.sv
// Module maxoh_decode
// Purpose : expands one unsigned VAL_W-bit value into a 2**VAL_W-bit one-hot code.
// Assumes : any input code is legal; exactly one output bit is ever set.
module maxoh_decode #(
    parameter int VAL_W = 4,
    localparam int NUM_CODES = 1 << VAL_W
) (
    input  logic [VAL_W-1:0]     val_i,
    output logic [NUM_CODES-1:0] hot_o
);

    // One equality term per output position.
    for (genvar v = 0; v < NUM_CODES; v++) begin : g_bit
        assign hot_o[v] = (val_i == VAL_W'(v));
    end

endmodule

// File: rtl/maxoh_or_tree.sv
// Module maxoh_or_tree
// Purpose : ORs N_IN bits into one, through a tree of RADIX-input OR nodes.
// Assumes : N_IN is a power of RADIX (the default is 256 = 4**4, four levels).
module maxoh_or_tree
    import maxoh_pkg::*;
#(
    parameter int N_IN  = 256,
    parameter int RADIX = 4
) (
    input  logic [N_IN-1:0] bits_i,
    output logic            any_o
);

    localparam int LEVELS = tree_levels(N_IN, RADIX);
    localparam int TOTAL  = level_offset(N_IN, RADIX, LEVELS) + 1;

    logic [TOTAL-1:0] node;

    // Leaves of the tree are the raw input bits.
    assign node[N_IN-1:0] = bits_i;

    // Each level folds groups of RADIX nodes from the level below.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int SRC    = level_offset(N_IN, RADIX, l);
        localparam int DST    = level_offset(N_IN, RADIX, l + 1);
        localparam int W_NEXT = level_width(N_IN, RADIX, l + 1);
        for (genvar j = 0; j < W_NEXT; j++) begin : g_node
            assign node[DST + j] = |node[SRC + j*RADIX +: RADIX];
        end
    end

    // The root is the last node.
    assign any_o = node[TOTAL-1];

endmodule

// File: rtl/maxoh_arbiter.sv
// Module maxoh_arbiter
// Purpose : keeps only the highest-numbered set request bit, using a ripple
//           "no grant yet" chain that runs from the top bit downward.
// Assumes : an all-zero request gives an all-zero grant.
module maxoh_arbiter #(
    parameter int N = 16
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);

    // free[i] is high when no bit at index i or above has been granted.
    logic [N:1] free;

    // The chain starts open above the top bit.
    assign free[N] = 1'b1;

    // A cell grants when it requests and the chain above it is still open.
    // The chain passes on only when that cell does not request.
    for (genvar i = N - 1; i >= 0; i--) begin : g_cell
        assign gnt_o[i] = req_i[i] & free[i+1];
        if (i >= 1) begin : g_pass
            assign free[i] = free[i+1] & ~req_i[i];
        end
    end

endmodule

// File: rtl/maxoh_encode.sv
// Module maxoh_encode
// Purpose : converts a one-hot vector into the binary index of its set bit.
// Assumes : at most one input bit is set; an all-zero input gives 0.
module maxoh_encode #(
    parameter int OUT_W = 4,
    localparam int N = 1 << OUT_W
) (
    input  logic [N-1:0]     hot_i,
    output logic [OUT_W-1:0] idx_o
);

    // Output bit b is the OR of every input position whose index has bit b set.
    for (genvar b = 0; b < OUT_W; b++) begin : g_out
        logic [N-1:0] sel;
        for (genvar i = 0; i < N; i++) begin : g_mask
            assign sel[i] = ((i >> b) & 1) != 0;
        end
        assign idx_o[b] = |(hot_i & sel);
    end

endmodule

// File: rtl/maxoh_max.sv
// Module maxoh_max
// Purpose : returns the largest of NUM_VALS unsigned VAL_W-bit lanes. The path is
//           decode to one-hot, OR per value into a presence vector, keep the
//           highest present value, then re-encode it.
// Assumes : purely combinational; lane k sits at vals_i[VAL_W*k +: VAL_W];
//           NUM_VALS is a power of OR_RADIX.
module maxoh_max #(
    parameter int NUM_VALS = 256,
    parameter int VAL_W    = 4,
    parameter int OR_RADIX = 4,
    localparam int NUM_CODES = 1 << VAL_W,
    localparam int BUS_W     = NUM_VALS * VAL_W
) (
    input  logic [BUS_W-1:0] vals_i,
    output logic [VAL_W-1:0] max_o
);

    logic [NUM_VALS-1:0][NUM_CODES-1:0] dec;       // per lane one-hot
    logic [NUM_CODES-1:0][NUM_VALS-1:0] col;       // per value, one bit per lane
    logic [NUM_CODES-1:0]               presence;  // value occurs somewhere
    logic [NUM_CODES-1:0]               grant;     // highest present value

    // Expand every lane into its one-hot code.
    for (genvar k = 0; k < NUM_VALS; k++) begin : g_lane
        maxoh_decode #(.VAL_W(VAL_W)) i_dec (
            .val_i (vals_i[VAL_W*k +: VAL_W]),
            .hot_o (dec[k])
        );
    end

    // Regroup the one-hot bits by value and reduce each group with an OR tree.
    for (genvar v = 0; v < NUM_CODES; v++) begin : g_code
        for (genvar k = 0; k < NUM_VALS; k++) begin : g_tap
            assign col[v][k] = dec[k][v];
        end
        maxoh_or_tree #(.N_IN(NUM_VALS), .RADIX(OR_RADIX)) i_tree (
            .bits_i (col[v]),
            .any_o  (presence[v])
        );
    end

    // Keep only the highest present value.
    maxoh_arbiter #(.N(NUM_CODES)) i_arb (
        .req_i (presence),
        .gnt_o (grant)
    );

    // Turn the winning position back into a number.
    maxoh_encode #(.OUT_W(VAL_W)) i_enc (
        .hot_i (grant),
        .idx_o (max_o)
    );

endmodule

// File: rtl/maxoh_max_chk.sv
// Module maxoh_max_chk
// Purpose : checks the relationship between the presence vector, the arbiter
//           grant and the encoded maximum inside maxoh_max.
// Assumes : bound to maxoh_max; the block has no clock, so the checks are
//           immediate and are evaluated whenever the inputs settle.
module maxoh_max_chk #(
    parameter int VAL_W = 4,
    localparam int NUM_CODES = 1 << VAL_W
) (
    input logic [NUM_CODES-1:0] presence,
    input logic [NUM_CODES-1:0] grant,
    input logic [VAL_W-1:0]     max_o
);

    logic [NUM_CODES-1:0] above;

    // Mark every value position strictly above the reported maximum.
    always_comb begin
        for (int i = 0; i < NUM_CODES; i++) above[i] = (i > int'(max_o));
    end

    // Cross-check the arbiter, the OR trees and the encoder against one another.
    always_comb begin
        p_grant_onehot_r7: assert ($countones(grant) == 1)
            else $error("grant is not one-hot: %b", grant);
        p_grant_in_presence_r7: assert ((grant & ~presence) == '0)
            else $error("grant %b outside presence %b", grant, presence);
        p_nothing_above_max_r5: assert ((presence & above) == '0)
            else $error("present value above max %0d: %b", max_o, presence);
        p_max_present_r1: assert (presence[max_o])
            else $error("max %0d not present: %b", max_o, presence);
        p_zero_floor_r3: assert ((max_o != '0) || (presence == NUM_CODES'(1)))
            else $error("max 0 with presence %b", presence);
    end

endmodule

bind maxoh_max maxoh_max_chk #(.VAL_W(VAL_W)) i_chk (
    .presence (presence),
    .grant    (grant),
    .max_o    (max_o)
);

// File: tb/test_maxoh_max.sv
// Bench test_maxoh_max
// Purpose : sweeps lane positions, uniform values, peaks over lower backgrounds
//           and random mixes; the expected maximum is computed in the bench.
module test_maxoh_max;

    localparam int NV = 256;
    localparam int VW = 4;
    localparam int BW = NV * VW;

    logic          clk;
    logic          rst_n;
    logic [BW-1:0] vals;
    logic [VW-1:0] max_o;
    int            n_checks;
    int            n_fail;
    bit            done;

    maxoh_max i_maxoh_max (
        .vals_i (vals),
        .max_o  (max_o)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Arithmetic maximum over all lanes.
    function automatic logic [VW-1:0] soft_max(input logic [BW-1:0] v);
        logic [VW-1:0] m;
        m = '0;
        for (int k = 0; k < NV; k++) if (v[VW*k +: VW] > m) m = v[VW*k +: VW];
        return m;
    endfunction

    // Compare the output with the expected value and record the result.
    task automatic check(input string req, input logic [VW-1:0] exp);
        n_checks++;
        if (max_o !== exp) begin
            n_fail++;
            $display("FAIL %s: max_o=%0d expected=%0d", req, max_o, exp);
        end
    endtask

    // Drive a vector on a rising edge and sample it on the following falling edge.
    task automatic apply(input logic [BW-1:0] v, input string req);
        @(posedge clk);
        vals = v;
        @(negedge clk);
        check(req, soft_max(v));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #900000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        logic [BW-1:0] v;
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        vals     = '0;
        rst_n    = 1'b0;

        // R3: all lanes zero while reset is held.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset/all-zero", 4'd0);
        rst_n = 1'b1;

        // R2: a lone 15 walked through every lane.
        for (int k = 0; k < NV; k++) begin
            v = '0;
            v[VW*k +: VW] = 4'hF;
            apply(v, "R2 lane walk");
        end

        // R3: back to all zero (also R6: the earlier 15 leaves no trace).
        apply('0, "R3 all-zero");
        check("R6 no memory", 4'd0);

        // R4: every lane equal, for each value.
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < NV; k++) v[VW*k +: VW] = VW'(m);
            apply(v, "R4 uniform");
        end

        // R5: one peak m over a random background of smaller values.
        for (int m = 1; m < 16; m++) begin
            for (int k = 0; k < NV; k++) v[VW*k +: VW] = VW'($urandom_range(m - 1, 0));
            v[VW*(($urandom % NV)) +: VW] = VW'(m);
            apply(v, "R5 peak over lower");
        end

        // R1: random mixes with a varied ceiling.
        for (int t = 0; t < 200; t++) begin
            int cap;
            cap = $urandom_range(15, 0);
            for (int k = 0; k < NV; k++) v[VW*k +: VW] = VW'($urandom_range(cap, 0));
            apply(v, "R1 random");
        end

        // R6: an input change between clock edges is followed at once.
        @(posedge clk);
        #1;
        vals = '0;
        vals[VW*7 +: VW] = 4'd9;
        #1;
        check("R6 between edges", 4'd9);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule